// File: doc/BRIEF.md
# Serialized Dual-Rail Inter-Tier Link

This block joins two synchronous routers on adjacent tiers of a stacked chip. On the sending side it takes a whole flit from the upstream router and cuts it into `SER_RATE` equal slices. The slices travel one after another over a narrow set of lanes. Each lane is a pair of data rails plus one returning acknowledge wire, so a link with `LANES = FLIT_W / SER_RATE` lanes uses `3*LANES` wires. On the receiving side the slices are put back together and the finished flit is handed to the downstream router as a one-cycle pulse.

Every slice goes through a four-phase return-to-null exchange. The sender drives a codeword. The receiver waits until every lane holds a legal codeword, stores the slice and raises its acknowledge. The sender then drives every lane to null, and the receiver drops the acknowledge once every lane reads null. Because completion is detected on every lane, a slow wire only stretches the exchange.

For the bench, each lane has a programmable extra delay (0 to `MAX_DLY` cycles) on all three of its wires. Each lane also has a short-circuit injection that forces its one-rail high whenever its zero-rail is high. A flit-level transaction acknowledge tells the upstream router when a new flit may begin.

Top module: `tier_link`

## Requirements
- R1: After reset, `flitValid` and `protoErr` are low, and `txnAck` follows `rxReady`.
- R2: Each delivered `flitOut` equals the flit accepted on `flitIn`. This holds for serialization rates 1, 2, 4 and 8 on a 16-bit flit.
- R3: Each accepted flit produces exactly one `flitValid` pulse, one cycle wide. The pulse comes after the receiver's slice counter has reached slice `SER_RATE-1` and wrapped.
- R4: A flit is accepted on a rising edge where `flitReq` and `txnAck` are both high. `txnAck` is then low from the next cycle until the flit has been delivered and the link is back at null.
- R5: While `rxReady` is low, `txnAck` is low and `flitReq` is ignored: no flit is delivered, and the next flit delivered is the one offered after `rxReady` returns.
- R6: Any per-lane extra delay from 0 to `MAX_DLY` cycles changes only latency, never data. Delays are changed only after the link has been idle for more than `MAX_DLY` cycles. The sender leaves a codeword only by going to null.
- R7: A lane that shows both rails high is an illegal codeword. It sets `protoErr`, which stays set until reset, and the slice that contains it is never completed.
- R8: Encoding: a lane sends logic 0 by raising its zero-rail and logic 1 by raising its one-rail. Slice `s` carries flit bits `[s*LANES +: LANES]`, with the least-significant slice sent first. A `railShort` lane that carries only ones therefore stays legal and delivers correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both routers |
| rstN | input | 1 | Active-low synchronous reset |
| flitIn | input | FLIT_W | Flit offered by the upstream router |
| flitReq | input | 1 | Upstream router has a flit to send |
| txnAck | output | 1 | A new flit may begin |
| rxReady | input | 1 | Downstream router can take a flit |
| laneDelay | input | LANES*DLY_W | Extra delay per lane, in cycles, lane 0 in the low bits |
| railShort | input | LANES | Per-lane fault: one-rail reads zero-rail OR one-rail |
| flitOut | output | FLIT_W | Rebuilt flit |
| flitValid | output | 1 | One-cycle pulse: `flitOut` holds a new flit |
| protoErr | output | 1 | Sticky illegal-codeword flag |

## Verification
Four links with rates 1, 2, 4 and 8 run in lockstep on the same flits.

- Walking ones and walking zeros show whether any bit lands in the wrong lane or slice, and this differs for every rate.
- All-zero, all-one and alternating flits test the rail encoding for both logic values.
- A random phase with random per-lane delays checks that completion detection tolerates skew between lanes.
- A short on the lane carrying bits 0, 4, 8 and 12 of the rate-4 link separates a flit that keeps that lane at one (legal) from a flit with a zero there (illegal and sticky). The other three links must be unaffected.

// File: rtl/tier_link_pkg.sv
package tier_link_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_RTZ  = 2'd2
  } txState_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic loadFlit;   // latch flitIn into the send buffer
    logic sendData;   // drive the current slice as a codeword (else null)
    logic capture;    // receiver stores the present slice
    logic lastSlice;  // stored slice is the final one of the flit
    logic ackLevel;   // receiver acknowledge wire level
  } strobe_t;

endpackage

// File: rtl/tier_link_dly.sv
module tier_link_dly #(
  parameter int W       = 1,
  parameter int MAX_DLY = 7,
  localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DLY_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);

  logic [W-1:0] stg [MAX_DLY];
  int unsigned  idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < MAX_DLY; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < MAX_DLY; k++) stg[k] <= stg[k-1];
    end
  end

  always_comb begin
    idx  = (int'(sel) > MAX_DLY) ? MAX_DLY : int'(sel);
    dout = (idx == 0) ? din : stg[idx-1];
  end

endmodule

// File: rtl/tier_link_ctrl.sv
module tier_link_ctrl
  import tier_link_pkg::*;
#(
  parameter int SER_RATE = 4,
  localparam int SEL_W   = (SER_RATE > 1) ? $clog2(SER_RATE) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flitReq,
  input  logic             rxReady,
  input  logic             allAckHigh,
  input  logic             allAckLow,
  input  logic             allValid,
  input  logic             allNull,
  input  logic             anyIllegal,
  output logic [SEL_W-1:0] txSel,
  output logic [SEL_W-1:0] rxSel,
  output strobe_t          strb,
  output logic             txnAck,
  output logic             flitValid,
  output logic             protoErr
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(SER_RATE - 1);

  txState_e txState;
  logic     ackQ;
  logic     rxIdle;
  logic     accept;
  logic     capture;
  logic     rxLast;

  assign rxIdle  = (rxSel == '0) && !ackQ;
  assign txnAck  = (txState == TX_IDLE) && rxIdle && rxReady;
  assign accept  = flitReq && txnAck;
  assign capture = allValid && !ackQ;
  assign rxLast  = (rxSel == LAST_SEL);

  always_comb begin
    strb.loadFlit  = accept;
    strb.sendData  = (txState == TX_SEND);
    strb.capture   = capture;
    strb.lastSlice = rxLast;
    strb.ackLevel  = ackQ;
  end

  // Sending side: one four-phase exchange per slice.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txSel   <= '0;
    end else begin
      unique case (txState)
        TX_IDLE: if (accept) begin
          txState <= TX_SEND;
          txSel   <= '0;
        end
        TX_SEND: if (allAckHigh) txState <= TX_RTZ;
        TX_RTZ: if (allAckLow) begin
          if (txSel == LAST_SEL) txState <= TX_IDLE;
          else begin
            txSel   <= txSel + 1'b1;
            txState <= TX_SEND;
          end
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  // Receiving side: acknowledge, slice counter, flit pulse, error flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ      <= 1'b0;
      rxSel     <= '0;
      flitValid <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      flitValid <= capture && rxLast;
      protoErr  <= protoErr | anyIllegal;
      if (capture) begin
        ackQ  <= 1'b1;
        rxSel <= rxLast ? '0 : rxSel + 1'b1;
      end else if (ackQ && allNull) begin
        ackQ <= 1'b0;
      end
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    flitValid |=> !flitValid);

  assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flitReq && txnAck) |=> !txnAck);

  assert_sticky_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  assert_ack_after_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackQ) |-> $past(allValid));

endmodule

// File: rtl/tier_link_dp.sv
module tier_link_dp
  import tier_link_pkg::*;
#(
  parameter int FLIT_W   = 32,
  parameter int SER_RATE = 4,
  parameter int MAX_DLY  = 7,
  localparam int LANES   = FLIT_W / SER_RATE,
  localparam int DLY_W   = $clog2(MAX_DLY + 1),
  localparam int SEL_W   = (SER_RATE > 1) ? $clog2(SER_RATE) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [FLIT_W-1:0]      flitIn,
  input  strobe_t                strb,
  input  logic [SEL_W-1:0]       txSel,
  input  logic [SEL_W-1:0]       rxSel,
  input  logic [LANES*DLY_W-1:0] laneDelay,
  input  logic [LANES-1:0]       railShort,
  output logic [FLIT_W-1:0]      flitOut,
  output logic                   allAckHigh,
  output logic                   allAckLow,
  output logic                   allValid,
  output logic                   allNull,
  output logic                   anyIllegal
);

  logic [FLIT_W-1:0] txBuf;
  logic [LANES-1:0]  txSlice;
  logic [LANES-1:0]  txR0, txR1;     // zero-rail, one-rail at the sender
  logic [LANES-1:0]  rxR0, rxR1;     // rails as seen at the receiver
  logic [LANES-1:0]  ackSeen;        // acknowledges as seen at the sender
  logic [FLIT_W-1:0] asmBuf, asmNext;

  assign txSlice = txBuf[txSel*LANES +: LANES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf <= '0;
      txR0  <= '0;
      txR1  <= '0;
    end else begin
      if (strb.loadFlit) txBuf <= flitIn;
      if (strb.sendData) begin
        txR1 <= txSlice;
        txR0 <= ~txSlice;
      end else begin
        txR1 <= '0;
        txR0 <= '0;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [1:0] railFar;

    tier_link_dly #(.W(2), .MAX_DLY(MAX_DLY)) u_fwd (
      .clk (clk),
      .rstN(rstN),
      .sel (laneDelay[l*DLY_W +: DLY_W]),
      .din ({txR1[l], txR0[l]}),
      .dout(railFar)
    );

    tier_link_dly #(.W(1), .MAX_DLY(MAX_DLY)) u_back (
      .clk (clk),
      .rstN(rstN),
      .sel (laneDelay[l*DLY_W +: DLY_W]),
      .din (strb.ackLevel),
      .dout(ackSeen[l])
    );

    assign rxR0[l] = railFar[0];
    assign rxR1[l] = railFar[1] | (railShort[l] & railFar[0]);
  end

  assign allValid   = &(rxR0 ^ rxR1);
  assign allNull    = ~|(rxR0 | rxR1);
  assign anyIllegal = |(rxR0 & rxR1);
  assign allAckHigh = &ackSeen;
  assign allAckLow  = ~|ackSeen;

  always_comb begin
    asmNext = asmBuf;
    asmNext[rxSel*LANES +: LANES] = rxR1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asmBuf  <= '0;
      flitOut <= '0;
    end else if (strb.capture) begin
      asmBuf <= asmNext;
      if (strb.lastSlice) flitOut <= asmNext;
    end
  end

  // Four-phase rule: a lane codeword is left only by returning to null.
  assert_rtz_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(txR0 | txR1)) |=> (((txR0 == $past(txR0)) && (txR1 == $past(txR1))) ||
                          ((txR0 | txR1) == '0)));

  assert_tx_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txR0 & txR1) == '0);

endmodule

// File: rtl/tier_link.sv
module tier_link
  import tier_link_pkg::*;
#(
  parameter int FLIT_W   = 32,
  parameter int SER_RATE = 4,
  parameter int MAX_DLY  = 7,
  localparam int LANES   = FLIT_W / SER_RATE,
  localparam int DLY_W   = $clog2(MAX_DLY + 1),
  localparam int SEL_W   = (SER_RATE > 1) ? $clog2(SER_RATE) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [FLIT_W-1:0]      flitIn,
  input  logic                   flitReq,
  output logic                   txnAck,
  input  logic                   rxReady,
  input  logic [LANES*DLY_W-1:0] laneDelay,
  input  logic [LANES-1:0]       railShort,
  output logic [FLIT_W-1:0]      flitOut,
  output logic                   flitValid,
  output logic                   protoErr
);

  initial assert (FLIT_W % SER_RATE == 0 && MAX_DLY >= 1)
    else $error("tier_link: SER_RATE must divide FLIT_W and MAX_DLY must be at least 1");

  strobe_t          strb;
  logic [SEL_W-1:0] txSel, rxSel;
  logic             allAckHigh, allAckLow, allValid, allNull, anyIllegal;

  tier_link_ctrl #(.SER_RATE(SER_RATE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flitReq   (flitReq),
    .rxReady   (rxReady),
    .allAckHigh(allAckHigh),
    .allAckLow (allAckLow),
    .allValid  (allValid),
    .allNull   (allNull),
    .anyIllegal(anyIllegal),
    .txSel     (txSel),
    .rxSel     (rxSel),
    .strb      (strb),
    .txnAck    (txnAck),
    .flitValid (flitValid),
    .protoErr  (protoErr)
  );

  tier_link_dp #(.FLIT_W(FLIT_W), .SER_RATE(SER_RATE), .MAX_DLY(MAX_DLY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .flitIn    (flitIn),
    .strb      (strb),
    .txSel     (txSel),
    .rxSel     (rxSel),
    .laneDelay (laneDelay),
    .railShort (railShort),
    .flitOut   (flitOut),
    .allAckHigh(allAckHigh),
    .allAckLow (allAckLow),
    .allValid  (allValid),
    .allNull   (allNull),
    .anyIllegal(anyIllegal)
  );

endmodule

// File: tb/tier_link_bench.sv
`timescale 1ns/1ps
module tier_link_bench;

  localparam int FW   = 16;
  localparam int MAXD = 7;
  localparam int DW   = 3;
  localparam int NR   = 4;   // rates 1, 2, 4, 8

  logic           clk = 1'b0;
  logic           rstN;
  logic [FW-1:0]  flitIn;
  logic           flitReq;
  logic           rxReady;
  logic [FW*DW-1:0] dlyAll;
  logic [FW-1:0]  shortAll;
  logic [NR-1:0]  ackV, fvV, errV;
  logic [FW-1:0]  foA [NR];

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NR; g++) begin : g_rate
    localparam int RT = 1 << g;
    localparam int LN = FW / RT;
    logic [FW-1:0] fo;
    logic a, v, e;

    tier_link #(.FLIT_W(FW), .SER_RATE(RT), .MAX_DLY(MAXD)) u_tier_link (
      .clk      (clk),
      .rstN     (rstN),
      .flitIn   (flitIn),
      .flitReq  (flitReq),
      .txnAck   (a),
      .rxReady  (rxReady),
      .laneDelay(dlyAll[LN*DW-1:0]),
      .railShort((g == 2) ? shortAll[LN-1:0] : {LN{1'b0}}),
      .flitOut  (fo),
      .flitValid(v),
      .protoErr (e)
    );

    assign foA[g]  = fo;
    assign ackV[g] = a;
    assign fvV[g]  = v;
    assign errV[g] = e;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitAllAck(input string tag);
    int n = 0;
    while (ackV != '1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(ackV == '1, tag, 32'(ackV), 32'hF);
  endtask

  // Waits out more than MAX_DLY idle cycles, then loads new lane delays.
  task automatic setDelays(input int mode);
    repeat (MAXD + 3) @(negedge clk);
    for (int l = 0; l < FW; l++)
      dlyAll[l*DW +: DW] = (mode == 0) ? 3'd0 : (mode == 1) ? 3'(MAXD) : 3'($urandom_range(0, MAXD));
  endtask

  task automatic sendFlit(input logic [FW-1:0] val, input string tag);
    int cnt [NR];
    logic [FW-1:0] got [NR];
    logic [NR-1:0] prev = '0;
    int n = 0;
    for (int r = 0; r < NR; r++) begin cnt[r] = 0; got[r] = '0; end
    waitAllAck({tag, " ready"});
    flitIn  = val;
    flitReq = 1'b1;
    @(negedge clk);
    flitReq = 1'b0;
    check(ackV == '0, "R4 txnAck low after accept", 32'(ackV), 32'h0);
    while (n < 4000) begin
      for (int r = 0; r < NR; r++) begin
        if (fvV[r]) begin
          cnt[r]++;
          got[r] = foA[r];
          if (prev[r]) check(1'b0, "R3 pulse wider than one cycle", 32'(r), 32'hFFFF);
        end
      end
      prev = fvV;
      if (ackV == '1) break;
      @(negedge clk);
      n++;
    end
    for (int r = 0; r < NR; r++) begin
      check(cnt[r] == 1, "R3 one pulse per flit", 32'(cnt[r]), 32'd1);
      check(got[r] == val, tag, 32'(got[r]), 32'(val));
    end
  endtask

  initial begin
    #(150000 * 5);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    flitIn   = '0;
    flitReq  = 1'b0;
    rxReady  = 1'b1;
    dlyAll   = '0;
    shortAll = '0;
    doReset();

    // R1 reset state
    check(fvV == '0, "R1 flitValid after reset", 32'(fvV), 32'h0);
    check(errV == '0, "R1 protoErr after reset", 32'(errV), 32'h0);
    check(ackV == '1, "R1 txnAck follows rxReady high", 32'(ackV), 32'hF);
    rxReady = 1'b0;
    @(negedge clk);
    check(ackV == '0, "R1 txnAck follows rxReady low", 32'(ackV), 32'h0);
    rxReady = 1'b1;
    @(negedge clk);

    // R2 fixed patterns, no extra delay
    for (int b = 0; b < FW; b++) sendFlit(FW'(1) << b, "R2 walking one");
    for (int b = 0; b < FW; b++) sendFlit(~(FW'(1) << b), "R2 walking zero");
    sendFlit(16'h0000, "R2 all zero");
    sendFlit(16'hFFFF, "R2 all one");
    sendFlit(16'hAAAA, "R2 alternating A");
    sendFlit(16'h5555, "R2 alternating 5");

    // R6 maximum delay on every lane, then random skew
    setDelays(1);
    sendFlit(16'hC3A5, "R6 max delay");
    sendFlit(16'h0F1E, "R6 max delay");
    for (int i = 0; i < 40; i++) begin
      setDelays(2);
      sendFlit(16'($urandom), "R6 random lane delay");
    end

    // R5 rxReady low: request ignored
    setDelays(0);
    rxReady = 1'b0;
    flitIn  = 16'hDEAD;
    flitReq = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (fvV != '0) seen++;
        if (ackV != '0) seen++;
      end
      check(seen == 0, "R5 no transfer while rxReady low", 32'(seen), 32'd0);
    end
    flitReq = 1'b0;
    rxReady = 1'b1;
    @(negedge clk);
    sendFlit(16'h1234, "R5 next flit is the new one");

    // R8 short on rate-4 lane 0 (bits 0,4,8,12) with ones there stays legal
    shortAll = 16'h0001;
    sendFlit(16'h1111, "R8 one-rail short keeps ones");
    check(errV == '0, "R8 no error with ones on shorted lane", 32'(errV), 32'h0);

    // R7 a zero on the shorted lane is illegal and sticky
    waitAllAck("R7 ready");
    flitIn  = 16'h1110;
    flitReq = 1'b1;
    @(negedge clk);
    flitReq = 1'b0;
    begin
      int got2 = 0;
      for (int i = 0; i < 200; i++) begin
        if (fvV[2]) got2++;
        for (int r = 0; r < NR; r++)
          if (r != 2 && fvV[r])
            check(foA[r] == 16'h1110, "R7 healthy links unaffected", 32'(foA[r]), 32'h1110);
        @(negedge clk);
      end
      check(got2 == 0, "R7 illegal slice never completes", 32'(got2), 32'd0);
    end
    check(errV == 4'b0100, "R7 protoErr set on shorted link", 32'(errV), 32'h4);
    shortAll = '0;
    repeat (20) @(negedge clk);
    check(errV[2] == 1'b1, "R7 protoErr sticky", 32'(errV[2]), 32'h1);

    doReset();
    check(errV == '0, "R1 reset clears protoErr", 32'(errV), 32'h0);
    check(ackV == '1, "R1 txnAck after reset", 32'(ackV), 32'hF);
    sendFlit(16'hBEEF, "R2 after recovery");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule